// File: doc/BRIEF.md
# Dual-Mode Glitch-Free System Clock Generator

This block produces a system clock signal from a fast master clock. It has two sources. In automatic mode the output follows a free-running oscillator level. In manual mode the output is high for as long as a debounced pushbutton is held. The output is a bit of the state register, so no combinational glitch can reach it. A separate output reports which mode is active.

All three asynchronous inputs pass through synchronizer chains before the state logic sees them. The controller has four states: a high and a low state for each mode. A request to change mode is acted on only from a low state, and only at the moment that low phase would end in its own mode. That moment is an oscillator rising edge in automatic mode and a button press in manual mode. At that moment the machine moves to the low state of the newly selected mode. As a result, a mode switch never shortens a high or low phase of the output.

Top module: `sysclk_gen`

## Requirements
- R1: While reset is asserted, `sclk_o` and `auto_mode_o` are both 0. By the sixth master clock edge after reset is released, `auto_mode_o` equals `auto_sel_i` (1 = automatic, 0 = manual) and `sclk_o` is still 0.
- R2: Each of `osc_i`, `auto_sel_i` and `button_i` passes through a two-flop synchronizer. A change that the state logic acts on shows at the outputs right after the third rising master edge following the input change.
- R3: In manual mode with manual still selected, `sclk_o` goes high when the synchronized button is pressed and low when it is released.
- R4: In automatic mode, a high phase starts only at a rising edge of the synchronized oscillator and ends when it goes low. Every automatic high phase therefore lasts exactly one oscillator high phase.
- R5: In automatic mode, `button_i` has no effect on either output.
- R6: A mode request that arrives during a high phase is deferred. The high phase completes, the machine enters its own mode's low state, and `auto_mode_o` changes only while `sclk_o` is low and stays low.
- R7: Automatic to manual: from the automatic low state, with manual selected, the switch happens at the next synchronized oscillator rising edge. The machine enters the manual low state and `sclk_o` stays low.
- R8: Manual to automatic: from the manual low state, with automatic selected, the switch happens at a synchronized button press. The machine enters the automatic low state and `sclk_o` stays low until the next oscillator rising edge.
- R9: `auto_mode_o` is 1 exactly while the machine is in an automatic state. It changes only at the events of R7 and R8, and once after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_i | input | 1 | Free-running oscillator level (asynchronous) |
| auto_sel_i | input | 1 | Mode request: 1 automatic, 0 manual (asynchronous) |
| button_i | input | 1 | Debounced pushbutton, 1 = pressed (asynchronous) |
| sclk_o | output | 1 | Generated system clock, a state register bit |
| auto_mode_o | output | 1 | Current mode: 1 automatic, 0 manual |

## Verification
The properties are written over the synchronized copies of the inputs. They take for granted that each input level lasts long enough to be seen by the synchronizer, so no pulse shorter than one master cycle is lost between two edges. The stimulus changes every input in the middle of a master cycle, holds each oscillator phase for five master cycles, and holds button and mode levels for at least one whole cycle. Each edge is therefore sampled exactly once, with the fixed latency given in R2.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  // bit 1 carries the mode (1 = automatic), bit 0 carries the output level
  localparam int unsigned MODE_BIT = 1;
  localparam int unsigned LVL_BIT  = 0;

  typedef enum logic [1:0] {
    ST_MAN_LO  = 2'b00,
    ST_MAN_HI  = 2'b01,
    ST_AUTO_LO = 2'b10,
    ST_AUTO_HI = 2'b11
  } gen_state_e;
endpackage

// File: rtl/sysclk_rst_sync.sv
module sysclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/sysclk_sync.sv
module sysclk_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  // synchronizer flops carry no reset; they settle while reset is held
  always_ff @(posedge clk_i) begin
    pipe_q[0] <= d_i;
    for (int i = 1; i < STAGES; i++) begin
      pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sysclk_fsm.sv
module sysclk_fsm
  import sysclk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_rise_i,
  input  logic       osc_i,
  input  logic       sel_i,
  input  logic       btn_i,
  output gen_state_e state_o,
  output logic       armed_o
);
  gen_state_e state_q, state_d;
  logic       armed_q;
  logic       state_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AUTO_HI: if (!osc_i)      state_d = ST_AUTO_LO;
      ST_AUTO_LO: if (osc_rise_i)  state_d = sel_i ? ST_AUTO_HI : ST_MAN_LO;
      ST_MAN_HI:  if (!btn_i)      state_d = ST_MAN_LO;
      ST_MAN_LO:  if (btn_i)       state_d = sel_i ? ST_AUTO_LO : ST_MAN_HI;
      default:                     state_d = ST_MAN_LO;
    endcase
  end

  assign state_en = (state_d != state_q);

  // state register; first cycle after reset loads the selected mode's low state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_MAN_LO;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      state_q <= sel_i ? ST_AUTO_LO : ST_MAN_LO;
      armed_q <= 1'b1;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/sysclk_gen.sv
module sysclk_gen
  import sysclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  input  logic auto_sel_i,
  input  logic button_i,
  output logic sclk_o,
  output logic auto_mode_o
);
  localparam int unsigned NUM_IN = 3;

  logic              rst_n_s;
  logic [NUM_IN-1:0] raw_in, sync_in;
  logic              osc_s, sel_s, btn_s;
  logic              osc_d_q;
  logic              osc_rise;
  logic              armed;
  gen_state_e        state;

  sysclk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  assign raw_in = {button_i, auto_sel_i, osc_i};

  sysclk_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  assign osc_s = sync_in[0];
  assign sel_s = sync_in[1];
  assign btn_s = sync_in[2];

  // previous oscillator sample for rising-edge detection
  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      osc_d_q <= 1'b0;
    end else begin
      osc_d_q <= osc_s;
    end
  end

  assign osc_rise = osc_s & ~osc_d_q;

  sysclk_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .osc_rise_i (osc_rise),
    .osc_i      (osc_s),
    .sel_i      (sel_s),
    .btn_i      (btn_s),
    .state_o    (state),
    .armed_o    (armed)
  );

  assign sclk_o      = state[LVL_BIT];
  assign auto_mode_o = state[MODE_BIT];
endmodule

// File: rtl/sysclk_gen_chk.sv
module sysclk_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic osc_s,
  input logic osc_d,
  input logic sel_s,
  input logic btn_s,
  input logic armed,
  input logic sclk_o,
  input logic auto_mode_o
);
  p_reset_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (!sclk_o && !auto_mode_o));

  p_rise_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(auto_mode_o) &&
      (auto_mode_o ? ($past(osc_s) && !$past(osc_d))
                   : ($past(btn_s) && !$past(sel_s))));

  p_fall_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $stable(auto_mode_o) &&
      (auto_mode_o ? !$past(osc_s) : !$past(btn_s)));

  p_mode_in_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(auto_mode_o) |-> (!sclk_o && !$past(sclk_o)));

  p_to_manual_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(auto_mode_o) |-> ($past(osc_s) && !$past(osc_d) && !$past(sel_s)));

  p_to_auto_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(auto_mode_o) && $past(armed)) |-> ($past(btn_s) && $past(sel_s)));
endmodule

bind sysclk_gen sysclk_gen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_n_s),
  .osc_s       (osc_s),
  .osc_d       (osc_d_q),
  .sel_s       (sel_s),
  .btn_s       (btn_s),
  .armed       (armed),
  .sclk_o      (sclk_o),
  .auto_mode_o (auto_mode_o)
);

// File: tb/sysclk_gen_test.sv
module sysclk_gen_test;
  localparam int OSC_HALF = 5;
  localparam int LATENCY  = 3;
  localparam int WATCHDOG = 100000;

  typedef struct {
    int    cyc;
    logic  sclk;
    logic  mode;
    string req;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst_ni;
  logic osc_i, auto_sel_i, button_i;
  logic sclk_o, auto_mode_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit streaming = 1'b0;
  bit done      = 1'b0;

  exp_item_t sb_q[$];

  // bench reference state
  logic mdl_mode, mdl_hi, mdl_po;
  int   osc_cnt = 0;
  logic osc_lvl = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sysclk_gen uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .osc_i       (osc_i),
    .auto_sel_i  (auto_sel_i),
    .button_i    (button_i),
    .sclk_o      (sclk_o),
    .auto_mode_o (auto_mode_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
               req, what, cyc, act, exp);
    end
  endtask

  // driver: one master cycle of stimulus, then push the outputs expected LATENCY edges later
  task automatic step(input logic m, input logic b, input string base);
    string tag;
    logic  rise;
    @(posedge clk);
    #5;
    osc_cnt++;
    if (osc_cnt == OSC_HALF) begin
      osc_cnt = 0;
      osc_lvl = ~osc_lvl;
    end
    osc_i      = osc_lvl;
    auto_sel_i = m;
    button_i   = b;
    tag  = base;
    rise = osc_lvl && !mdl_po;
    if (mdl_hi && (m != mdl_mode)) tag = "R6";
    if (mdl_mode) begin
      if (mdl_hi) begin
        if (!osc_lvl) mdl_hi = 1'b0;
      end else if (rise) begin
        if (m) mdl_hi = 1'b1;
        else begin mdl_mode = 1'b0; tag = "R7"; end
      end
    end else begin
      if (mdl_hi) begin
        if (!b) mdl_hi = 1'b0;
      end else if (b) begin
        if (!m) mdl_hi = 1'b1;
        else begin mdl_mode = 1'b1; tag = "R8"; end
      end
    end
    mdl_po = osc_lvl;
    sb_q.push_back('{cyc: cyc + LATENCY, sclk: mdl_hi, mode: mdl_mode, req: tag});
  endtask

  // monitor: compares scoreboard items and measures automatic high phases
  initial begin : monitor
    exp_item_t it;
    int hi_len = 0;
    forever begin
      @(posedge clk);
      #2;
      while (sb_q.size() > 0 && sb_q[0].cyc < cyc) begin
        it = sb_q.pop_front();
        chk(1'b0, it.req, "missed sample", 0, it.cyc);
      end
      if (sb_q.size() > 0 && sb_q[0].cyc == cyc) begin
        it = sb_q.pop_front();
        chk(sclk_o == it.sclk, it.req, "sclk_o", int'(sclk_o), int'(it.sclk));
        chk(auto_mode_o == it.mode, it.req, "auto_mode_o", int'(auto_mode_o), int'(it.mode));
      end
      if (streaming) begin
        if (sclk_o && auto_mode_o) hi_len++;
        else if (hi_len > 0) begin
          chk(hi_len == OSC_HALF, "R4", "auto high phase length", hi_len, OSC_HALF);
          hi_len = 0;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stimulus
    logic m, b;
    rst_ni     = 1'b0;
    osc_i      = 1'b0;
    auto_sel_i = 1'b1;
    button_i   = 1'b0;
    repeat (6) @(posedge clk);
    #5;
    chk(sclk_o == 1'b0, "R1", "sclk_o in reset", int'(sclk_o), 0);
    chk(auto_mode_o == 1'b0, "R1", "auto_mode_o in reset", int'(auto_mode_o), 0);
    rst_ni = 1'b1;
    repeat (6) @(posedge clk);
    #5;
    chk(auto_mode_o == 1'b1, "R1", "auto_mode_o after reset", int'(auto_mode_o), 1);
    chk(sclk_o == 1'b0, "R1", "sclk_o after reset", int'(sclk_o), 0);

    mdl_mode  = 1'b1;
    mdl_hi    = 1'b0;
    mdl_po    = 1'b0;
    streaming = 1'b1;

    // automatic mode with a busy button
    for (int i = 0; i < 200; i++) step(1'b1, 1'(($urandom() % 2)), "R5");

    // request manual; then button held for random stretches
    b = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (($urandom() % 6) == 0) b = ~b;
      step(1'b0, b, "R3");
    end

    // latency: release, wait, then a single press
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, "R2");
    for (int i = 0; i < 6; i++)  step(1'b0, 1'b1, "R2");
    for (int i = 0; i < 6; i++)  step(1'b0, 1'b0, "R2");

    // randomly timed mode switches with random button activity
    m = 1'b0;
    b = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (($urandom() % 40) == 0) m = ~m;
      if (($urandom() % 8) == 0)  b = ~b;
      step(m, b, "R9");
    end

    for (int i = 0; i < LATENCY + 2; i++) step(m, 1'b0, "R9");
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule